// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block sequences a dual-slope integrating measurement around an external analog integrator and a zero-crossing comparator. A conversion starts when `start` is seen while the block is idle. The block first closes a shorting switch across the integrator for a set number of cycles. It then connects the unknown input for a fixed run-up length. Next it connects a reference whose polarity opposes the integrated charge, and counts clock cycles until the comparator reports that the integrator has crossed zero. That count is the measured value.

The comparator level seen in the last run-up cycle decides which reference is applied, and it is reported as the result's sign. A longer run-up gives a finer result but a slower conversion, so both the run-up length and the shorting length come in on ports. They are captured when the conversion starts. The run-down is cut off at twice the run-up length. When that happens the result is marked over-range and the integrator is shorted again before the result is posted. Each result stays on the outputs with a valid flag until it is acknowledged.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_n` is low and on the cycle after it rises, all four switch outputs, `busy` and `res_valid` are 0.
- R2: `start` is acted on only while `busy` is 0. A `start` pulse while a result awaits acknowledgement leaves `res_valid` at 1, keeps the switches open, and does not begin a new conversion after the acknowledgement.
- R3: Each conversion begins with `sw_short` high for exactly max(Z,1) consecutive cycles, where Z is `cfg_zero_len` sampled in the cycle `start` is accepted.
- R4: `sw_input` is high for exactly max(N,1) consecutive cycles, where N is `cfg_runup_len` sampled with `start`. Its first cycle directly follows the last shorting cycle.
- R5: The value of `comp_pos` in the last run-up cycle becomes `res_pos`. If that value is 1, only `sw_ref_neg` is driven during run-down; if it is 0, only `sw_ref_pos` is driven.
- R6: The run-down cycles are numbered from 0. `res_count` is the number of the first run-down cycle in which `comp_pos` differs from `res_pos`, and the reference stays on for `res_count`+1 cycles.
- R7: If `comp_pos` does not change in run-down cycles 0 through 2·max(N,1), the block ends run-down after 2·max(N,1)+1 cycles. It then shorts the integrator for another max(Z,1) cycles and posts `res_ovr`=1 with `res_count`=2·max(N,1). A crossing found in cycle 2·max(N,1) itself still gives a normal result with `res_ovr`=0.
- R8: `res_valid` rises when run-down ends (or after the over-range shorting). `res_count`, `res_pos` and `res_ovr` stay constant while it is high. `res_valid` and `busy` are 0 in the cycle after a cycle with `res_ack` high.
- R9: At most one of `sw_short`, `sw_input`, `sw_ref_pos`, `sw_ref_neg` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a conversion; acted on only when idle |
| cfg_zero_len | input | CW | Shorting length in cycles (0 treated as 1) |
| cfg_runup_len | input | CW | Run-up length in cycles (0 treated as 1) |
| comp_pos | input | 1 | Comparator: 1 when integrator output is above zero |
| res_ack | input | 1 | Acknowledge of the posted result |
| sw_short | output | 1 | Close the integrator shorting switch |
| sw_input | output | 1 | Connect the unknown input to the integrator |
| sw_ref_pos | output | 1 | Connect the positive reference |
| sw_ref_neg | output | 1 | Connect the negative reference |
| busy | output | 1 | Conversion in progress or result pending |
| res_valid | output | 1 | Result posted and held |
| res_count | output | CW+1 | Run-down cycle count |
| res_pos | output | 1 | Sign: 1 when the integrated input was positive |
| res_ovr | output | 1 | Run-down exceeded twice the run-up length |

## Verification
The bench models the integrator as a signed sum fed by the switch outputs and drives the comparator from it. Positive and negative inputs of different sizes over several run-up lengths separate the two reference paths and the count arithmetic. A zero input shows that the sign depends on the comparator level alone. An input whose crossing lands exactly in cycle 2N, and inputs just past that on both signs, test the over-range limit and its extra shorting. Zero-valued lengths, where the sign is taken from an integrator that has seen only the shorting switch, check the minimum-length rule.

// File: rtl/dslope_pkg.sv
// Shared types for the dual-slope sequencer.
// Assumes nothing beyond a single clock domain.
package dslope_pkg;

    // Conversion phases; encoding is internal only.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SHORT = 3'd1,
        PH_RUNUP = 3'd2,
        PH_RUNDN = 3'd3,
        PH_DUMP  = 3'd4,
        PH_HOLD  = 3'd5
    } phase_t;

endpackage

// File: rtl/dslope_tick_cnt.sv
// Cycle counter shared by all timed phases.
// Clears on request, otherwise counts up by one each cycle.
// Assumes the owner clears it before the value can wrap.
module dslope_tick_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count cycles in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/dslope_phase_fsm.sv
// Phase controller for the dual-slope conversion.
// Captures the lengths on start, steps through short, run-up and run-down,
// latches the comparator sign at the end of run-up, and detects the zero
// crossing or the over-range limit (twice the run-up length).
// Assumes comp_pos is already synchronous to clk.
module dslope_phase_fsm
    import dslope_pkg::*;
#(
    parameter int CW = 10,
    parameter int RW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_zero_len,
    input  logic [CW-1:0] cfg_runup_len,
    input  logic          comp_pos,
    input  logic          res_valid,
    input  logic          res_ack,
    input  logic [RW-1:0] cnt,
    output logic          cnt_clr,
    output phase_t        phase,
    output logic          pol,
    output logic          cap,
    output logic [RW-1:0] cap_cnt,
    output logic          cap_ovr
);

    localparam logic [RW-1:0] ONE = RW'(1);

    phase_t        st, nxt;
    logic [CW-1:0] zlen_q, nlen_q;
    logic          pol_q;
    logic [RW-1:0] lim;
    logic          last_z, last_n, crossed, at_lim;

    assign lim     = {nlen_q, 1'b0};
    assign last_z  = (cnt == ({1'b0, zlen_q} - ONE));
    assign last_n  = (cnt == ({1'b0, nlen_q} - ONE));
    assign crossed = (comp_pos != pol_q);
    assign at_lim  = (cnt == lim);

    // Next-phase and counter-clear decisions.
    always_comb begin
        nxt     = st;
        cnt_clr = 1'b0;
        cap     = 1'b0;
        case (st)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (start) nxt = PH_SHORT;
            end
            PH_SHORT: begin
                if (last_z) begin
                    nxt     = PH_RUNUP;
                    cnt_clr = 1'b1;
                end
            end
            PH_RUNUP: begin
                if (last_n) begin
                    nxt     = PH_RUNDN;
                    cnt_clr = 1'b1;
                end
            end
            PH_RUNDN: begin
                if (crossed) begin
                    nxt = PH_HOLD;
                    cap = 1'b1;
                end else if (at_lim) begin
                    nxt     = PH_DUMP;
                    cnt_clr = 1'b1;
                end
            end
            PH_DUMP: begin
                if (last_z) begin
                    nxt = PH_HOLD;
                    cap = 1'b1;
                end
            end
            PH_HOLD: begin
                cnt_clr = 1'b1;
                if (res_valid && res_ack) nxt = PH_IDLE;
            end
            default: begin
                nxt     = PH_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= PH_IDLE;
        else
            st <= nxt;
    end

    // Capture lengths when a conversion is accepted; zero means one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zlen_q <= CW'(1);
            nlen_q <= CW'(1);
        end else if (st == PH_IDLE && start) begin
            zlen_q <= (cfg_zero_len  == '0) ? CW'(1) : cfg_zero_len;
            nlen_q <= (cfg_runup_len == '0) ? CW'(1) : cfg_runup_len;
        end
    end

    // Latch the comparator level in the last run-up cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= 1'b0;
        else if (st == PH_RUNUP && last_n)
            pol_q <= comp_pos;
    end

    assign phase   = st;
    assign pol     = pol_q;
    assign cap_ovr = (st == PH_DUMP);
    assign cap_cnt = (st == PH_DUMP) ? lim : cnt;

    AST_RUNUP_AFTER_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_RUNUP && $past(st) != PH_RUNUP) |-> $past(st) == PH_SHORT); // R4

    AST_POL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_RUNDN && $past(st) == PH_RUNDN) |-> $stable(pol_q)); // R5

    AST_RUNDN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_RUNDN) |-> (cnt <= lim)); // R7

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HOLD && !(res_valid && res_ack)) |=> (st == PH_HOLD)); // R2

endmodule

// File: rtl/dslope_switch_dec.sv
// Decodes the phase into the analog switch controls and the busy flag.
// The reference opposing the captured sign is the one driven in run-down.
// Assumes phase is a registered value so the outputs are glitch-free.
module dslope_switch_dec
    import dslope_pkg::*;
(
    input  phase_t phase,
    input  logic   pol,
    output logic   sw_short,
    output logic   sw_input,
    output logic   sw_ref_pos,
    output logic   sw_ref_neg,
    output logic   busy
);

    // One switch per phase, reference chosen by captured sign.
    always_comb begin
        sw_short   = (phase == PH_SHORT) || (phase == PH_DUMP);
        sw_input   = (phase == PH_RUNUP);
        sw_ref_pos = (phase == PH_RUNDN) && !pol;
        sw_ref_neg = (phase == PH_RUNDN) &&  pol;
        busy       = (phase != PH_IDLE);
    end

endmodule

// File: rtl/dslope_result_hold.sv
// Holds the finished result with a valid flag until acknowledged.
// Assumes cap never coincides with a pending result.
module dslope_result_hold #(
    parameter int RW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [RW-1:0] cap_cnt,
    input  logic          cap_pos,
    input  logic          cap_ovr,
    input  logic          res_ack,
    output logic          res_valid,
    output logic [RW-1:0] res_count,
    output logic          res_pos,
    output logic          res_ovr
);

    // Valid flag: set on capture, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_valid <= 1'b0;
        else if (cap)
            res_valid <= 1'b1;
        else if (res_ack)
            res_valid <= 1'b0;
    end

    // Result fields load only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_count <= '0;
            res_pos   <= 1'b0;
            res_ovr   <= 1'b0;
        end else if (cap) begin
            res_count <= cap_cnt;
            res_pos   <= cap_pos;
            res_ovr   <= cap_ovr;
        end
    end

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_count)
                                     && $stable(res_pos) && $stable(res_ovr))); // R8

endmodule

// File: rtl/dslope_seq.sv
// Top of the dual-slope conversion sequencer.
// Wires the phase controller, the cycle counter, the switch decoder and
// the result holder. Assumes an external integrator and comparator.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_zero_len,
    input  logic [CW-1:0] cfg_runup_len,
    input  logic          comp_pos,
    input  logic          res_ack,
    output logic          sw_short,
    output logic          sw_input,
    output logic          sw_ref_pos,
    output logic          sw_ref_neg,
    output logic          busy,
    output logic          res_valid,
    output logic [CW:0]   res_count,
    output logic          res_pos,
    output logic          res_ovr
);

    localparam int RW = CW + 1;

    logic [RW-1:0] cnt;
    logic          cnt_clr;
    phase_t        phase;
    logic          pol;
    logic          cap;
    logic [RW-1:0] cap_cnt;
    logic          cap_ovr;

    dslope_tick_cnt #(.W(RW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    dslope_phase_fsm #(.CW(CW), .RW(RW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_zero_len  (cfg_zero_len),
        .cfg_runup_len (cfg_runup_len),
        .comp_pos      (comp_pos),
        .res_valid     (res_valid),
        .res_ack       (res_ack),
        .cnt           (cnt),
        .cnt_clr       (cnt_clr),
        .phase         (phase),
        .pol           (pol),
        .cap           (cap),
        .cap_cnt       (cap_cnt),
        .cap_ovr       (cap_ovr)
    );

    dslope_switch_dec u_dec (
        .phase      (phase),
        .pol        (pol),
        .sw_short   (sw_short),
        .sw_input   (sw_input),
        .sw_ref_pos (sw_ref_pos),
        .sw_ref_neg (sw_ref_neg),
        .busy       (busy)
    );

    dslope_result_hold #(.RW(RW)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_cnt   (cap_cnt),
        .cap_pos   (pol),
        .cap_ovr   (cap_ovr),
        .res_ack   (res_ack),
        .res_valid (res_valid),
        .res_count (res_count),
        .res_pos   (res_pos),
        .res_ovr   (res_ovr)
    );

endmodule

// File: tb/dslope_seq_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor
// compares them with what the design posts. The integrator is a signed sum.
module dslope_seq_tb;

    localparam int CW   = 10;
    localparam int VREF = 8;

    typedef struct {
        int cnt; int pos; int ovr; int zc; int uc; int rp; int rn;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cfg_zero_len = '0;
    logic [CW-1:0] cfg_runup_len = '0;
    logic          comp_pos;
    logic          res_ack = 1'b0;
    logic          sw_short, sw_input, sw_ref_pos, sw_ref_neg, busy;
    logic          res_valid, res_pos, res_ovr;
    logic [CW:0]   res_count;

    int   total = 0;
    int   bad = 0;
    int   vin = 0;
    int   integ = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    assign comp_pos = (integ > 0);

    dslope_seq #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_zero_len(cfg_zero_len), .cfg_runup_len(cfg_runup_len),
        .comp_pos(comp_pos), .res_ack(res_ack),
        .sw_short(sw_short), .sw_input(sw_input),
        .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg), .busy(busy),
        .res_valid(res_valid), .res_count(res_count),
        .res_pos(res_pos), .res_ovr(res_ovr)
    );

    // Integrator model driven by the switch outputs.
    always @(posedge clk) begin
        if (sw_short)        integ <= 0;
        else if (sw_input)   integ <= integ + vin;
        else if (sw_ref_pos) integ <= integ + VREF;
        else if (sw_ref_neg) integ <= integ - VREF;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: per-conversion switch statistics and scoreboard compare.
    int  zc = 0, uc = 0, rp = 0, rn = 0;
    bit  excl_bad = 0, order_bad = 0, got = 0, prev_short = 0, prev_in = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((int'(sw_short) + int'(sw_input) + int'(sw_ref_pos) + int'(sw_ref_neg)) > 1)
                excl_bad = 1;
            if (sw_input && !prev_in && !prev_short) order_bad = 1;
            if (sw_short)   zc++;
            if (sw_input)   uc++;
            if (sw_ref_pos) rp++;
            if (sw_ref_neg) rn++;
            prev_short = sw_short;
            prev_in = sw_input;
            if (res_valid && !got) begin
                got = 1;
                if (q.size() == 0) begin
                    chk(0, "R8 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(int'(res_count) == e.cnt, "R6 count", int'(res_count), e.cnt);
                    chk(int'(res_pos) == e.pos, "R5 sign", int'(res_pos), e.pos);
                    chk(int'(res_ovr) == e.ovr, "R7 over-range", int'(res_ovr), e.ovr);
                    chk(zc == e.zc, "R3 short cycles", zc, e.zc);
                    chk(uc == e.uc, "R4 run-up cycles", uc, e.uc);
                    chk(rp == e.rp, "R5 pos-ref cycles", rp, e.rp);
                    chk(rn == e.rn, "R6 neg-ref cycles", rn, e.rn);
                    chk(!excl_bad, "R9 switch exclusive", int'(excl_bad), 0);
                    chk(!order_bad, "R4 run-up follows short", int'(order_bad), 0);
                end
                zc = 0; uc = 0; rp = 0; rn = 0; excl_bad = 0; order_bad = 0;
            end
            if (!res_valid) got = 0;
        end
    end

    // Driver: compute the expected outcome, run one conversion, handshake.
    task automatic run(input int n, input int z, input int v);
        exp_t e;
        int neff, zeff, s, v0, k, rc, held;
        neff = (n == 0) ? 1 : n;
        zeff = (z == 0) ? 1 : z;
        s  = (((neff - 1) * v) > 0) ? 1 : 0;
        v0 = neff * v;
        k  = -1;
        for (int kk = 0; kk <= 2 * neff; kk++) begin
            int vk;
            vk = s ? (v0 - kk * VREF) : (v0 + kk * VREF);
            if (k < 0 && (s ? (vk <= 0) : (vk > 0))) k = kk;
        end
        if (k < 0) begin
            e.cnt = 2 * neff; e.ovr = 1; rc = 2 * neff + 1; e.zc = 2 * zeff;
        end else begin
            e.cnt = k; e.ovr = 0; rc = k + 1; e.zc = zeff;
        end
        e.pos = s; e.uc = neff;
        e.rp = s ? 0 : rc;
        e.rn = s ? rc : 0;
        q.push_back(e);

        @(negedge clk);
        vin = v;
        cfg_zero_len  = CW'(z);
        cfg_runup_len = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_zero_len  = '0;
        cfg_runup_len = '0;
        while (!res_valid) @(negedge clk);
        held = int'(res_count);
        @(negedge clk);
        start = 1'b1;                       // R2: must be ignored
        @(negedge clk);
        start = 1'b0;
        chk(res_valid && !sw_short && !sw_input && !sw_ref_pos && !sw_ref_neg,
            "R2 start ignored while pending", int'(res_valid), 1);
        chk(int'(res_count) == held, "R8 result held", int'(res_count), held);
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(!res_valid && !busy, "R8 cleared after ack", int'(res_valid) + int'(busy), 0);
        @(negedge clk);
        chk(!busy && !sw_short, "R2 no conversion from ignored start", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sw_short && !sw_input && !sw_ref_pos && !sw_ref_neg && !busy && !res_valid,
            "R1 outputs in reset", int'(busy) + int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !res_valid && !sw_short, "R1 idle after reset",
            int'(busy) + int'(res_valid), 0);

        run(16, 3, 5);      // positive input
        run(16, 3, -5);     // negative input
        run(16, 2, 0);      // zero input
        run(16, 4, 16);     // crossing exactly at 2N
        run(16, 3, 17);     // over-range, positive
        run(16, 2, -17);    // over-range, negative
        run(0, 0, 3);       // minimum lengths
        run(40, 5, -3);
        run(64, 1, 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1ms;
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule